// File: doc/BRIEF.md
# Rate-Selectable Convolutional Encoder Symbol Sequencer

This block turns a serial stream of data bits into a serial stream of coded symbols using a constraint-length-7 convolutional code with three generator polynomials. Each data bit arrives with a one-cycle data strobe and is shifted into a 7-stage register. Three parity symbols, G1, G2 and G3, are formed from that register. A separate output strobe loads one of these symbols into a one-bit output register.

Two sequencing modes choose which symbol is loaded. In external mode, a 2-bit select input names the symbol for each output strobe. In automatic mode, the block steps through G1 and G2 (rate 1/2) or through G1, G2 and G3 (rate 1/3) on successive output strobes, and it starts again at G1 on every data strobe. A scramble input inverts G2 in both modes, so that an all-zero data stream does not produce an all-zero symbol stream. Both strobes are synchronous enables in one clock domain.

Top module: `conv_symbol_encoder`

## Requirements
- R1: While `rst_n` is low, the shift register, the sequencing phase and `sym_out` are cleared asynchronously. Every symbol of the cleared register is 0.
- R2: On each cycle with `data_stb` high, stage 0 takes `data_in` and stage k takes the old stage k-1. With `data_stb` low, the register holds.
- R3: The symbol Gx is the XOR of the register stages selected by its polynomial. Bit k of the polynomial taps stage k, and stage 0 is the newest bit. The polynomials are G1 = 171 octal, G2 = 133 octal and G3 = 145 octal.
- R4: `sym_out` changes only on the clock edge after a cycle with `latch_stb` high. In external mode (`auto_mode`=0), `sel` 00 loads G1, 10 loads G2 and 01 loads G3.
- R5: In external mode, `sel` = 11 on an output strobe leaves `sym_out` unchanged.
- R6: In automatic mode with `rate_half`=0, successive output strobes after a data strobe load G1, G2, G3, and then G1 again.
- R7: In automatic mode with `rate_half`=1, successive output strobes load G1, G2, and then G1 again. In automatic mode, `sel` has no effect.
- R8: In external mode, `rate_half` has no effect on the loaded symbol.
- R9: With `scramble`=1, G2 is inverted when it is loaded, in both modes. G1 and G3 are never inverted.
- R10: A data strobe restarts the automatic sequence, so the next output strobe loads G1 of the new register contents.
- R11: When `data_stb` and `latch_stb` are high in the same cycle, the latch uses the register and phase from before the shift. The following output strobe loads G1 of the shifted register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_stb | input | 1 | Data strobe; shifts `data_in` into the register |
| data_in | input | 1 | Serial data bit |
| latch_stb | input | 1 | Output strobe; loads one symbol into `sym_out` |
| auto_mode | input | 1 | 1: automatic sequencing; 0: external select |
| sel | input | 2 | External symbol select (00 G1, 10 G2, 01 G3, 11 hold) |
| rate_half | input | 1 | Automatic mode only: 1 selects rate 1/2, 0 selects rate 1/3 |
| scramble | input | 1 | Inverts G2 on output when high |
| sym_out | output | 1 | Registered output symbol |

## Verification
Every one of the 128 register contents is loaded through the data strobe and then read back with each select code. This separates the three polynomials from each other and from the hold code. During these reads, `scramble` and `rate_half` are driven from register bits, which shows that only G2 reacts to `scramble` and that external mode ignores the rate input. Pseudo-random bit streams in both automatic rates are checked with extra output strobes and junk `sel` values; these catch wrong wrap points and leakage from the select input. Short patterns then place a data strobe between output strobes, or in the same cycle as one, to tell sequence restart apart from pre-shift sampling.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;

    localparam int unsigned NUM_GEN = 3;
    localparam int unsigned PH_W    = $clog2(NUM_GEN);

    typedef logic [PH_W-1:0] phase_t;

    typedef enum logic [1:0] {
        SEL_G1   = 2'b00,
        SEL_G3   = 2'b01,
        SEL_G2   = 2'b10,
        SEL_HOLD = 2'b11
    } sel_code_t;

    typedef struct packed {
        phase_t phase;
        logic   sym;
    } seq_state_t;

    localparam phase_t PH_G1 = phase_t'(0);
    localparam phase_t PH_G2 = phase_t'(1);
    localparam phase_t PH_G3 = phase_t'(2);

endpackage

// File: rtl/conv_enc_shifter.sv
module conv_enc_shifter #(
    parameter int unsigned K = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         data_stb,
    input  logic         data_in,
    output logic [K-1:0] stages
);

    typedef struct packed {
        logic [K-1:0] bits;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (data_stb) begin
            st_d.bits = {st_q.bits[K-2:0], data_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stages = st_q.bits;

    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |=> (stages[0] == $past(data_in)) && (stages[K-1:1] == $past(stages[K-2:0])));

    p_shift_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !data_stb |=> $stable(stages));

endmodule

// File: rtl/conv_enc_gen.sv
module conv_enc_gen
    import conv_enc_pkg::*;
#(
    parameter int unsigned               K     = 7,
    parameter logic [NUM_GEN*K-1:0]      POLYS = '0
) (
    input  logic [K-1:0]       stages,
    output logic [NUM_GEN-1:0] gen_sym
);

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_parity
        localparam logic [K-1:0] TAPS = POLYS[g*K +: K];
        assign gen_sym[g] = ^(stages & TAPS);
    end

endmodule

// File: rtl/conv_enc_seq.sv
module conv_enc_seq
    import conv_enc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               data_stb,
    input  logic               latch_stb,
    input  logic               auto_mode,
    input  logic [1:0]         sel,
    input  logic               rate_half,
    input  logic               scramble,
    input  logic [NUM_GEN-1:0] gen_sym,
    output logic               sym_out
);

    seq_state_t         q_d, q_q;
    logic [NUM_GEN-1:0] cand;
    phase_t             last_ph;
    logic               auto_sym;

    always_comb begin
        cand    = gen_sym;
        cand[1] = gen_sym[1] ^ scramble;
        last_ph = rate_half ? PH_G2 : PH_G3;

        case (q_q.phase)
            PH_G1:   auto_sym = cand[0];
            PH_G2:   auto_sym = cand[1];
            default: auto_sym = cand[2];
        endcase

        q_d = q_q;
        if (latch_stb) begin
            if (auto_mode) begin
                q_d.sym   = auto_sym;
                q_d.phase = (q_q.phase >= last_ph) ? PH_G1 : q_q.phase + phase_t'(1);
            end else begin
                case (sel_code_t'(sel))
                    SEL_G1:  q_d.sym = cand[0];
                    SEL_G2:  q_d.sym = cand[1];
                    SEL_G3:  q_d.sym = cand[2];
                    default: q_d.sym = q_q.sym;
                endcase
            end
        end
        if (data_stb) begin
            q_d.phase = PH_G1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign sym_out = q_q.sym;

    p_latch_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_stb |=> $stable(sym_out));

    p_ext_g1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_stb && !auto_mode && sel == 2'b00) |=> (sym_out == $past(gen_sym[0])));

    p_hold_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_stb && !auto_mode && sel == 2'b11) |=> $stable(sym_out));

    p_ext_g2_scramble_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_stb && !auto_mode && sel == 2'b10) |=> (sym_out == ($past(gen_sym[1]) ^ $past(scramble))));

    p_phase_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.phase != 2'd3);

    p_half_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && rate_half && latch_stb && !data_stb && q_q.phase == PH_G2) |=> (q_q.phase == PH_G1));

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |=> (q_q.phase == PH_G1));

endmodule

// File: rtl/conv_symbol_encoder.sv
module conv_symbol_encoder
    import conv_enc_pkg::*;
#(
    parameter int unsigned  K       = 7,
    parameter logic [K-1:0] POLY_G1 = 'o171,
    parameter logic [K-1:0] POLY_G2 = 'o133,
    parameter logic [K-1:0] POLY_G3 = 'o145
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data_stb,
    input  logic       data_in,
    input  logic       latch_stb,
    input  logic       auto_mode,
    input  logic [1:0] sel,
    input  logic       rate_half,
    input  logic       scramble,
    output logic       sym_out
);

    localparam logic [NUM_GEN*K-1:0] POLYS = {POLY_G3, POLY_G2, POLY_G1};

    logic [K-1:0]       stages;
    logic [NUM_GEN-1:0] gen_sym;

    conv_enc_shifter #(.K(K)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_stb (data_stb),
        .data_in  (data_in),
        .stages   (stages)
    );

    conv_enc_gen #(.K(K), .POLYS(POLYS)) u_gen (
        .stages  (stages),
        .gen_sym (gen_sym)
    );

    conv_enc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_stb  (data_stb),
        .latch_stb (latch_stb),
        .auto_mode (auto_mode),
        .sel       (sel),
        .rate_half (rate_half),
        .scramble  (scramble),
        .gen_sym   (gen_sym),
        .sym_out   (sym_out)
    );

endmodule

// File: tb/conv_symbol_encoder_test.sv
module conv_symbol_encoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_stb = 1'b0, data_in = 1'b0, latch_stb = 1'b0;
    logic       auto_mode = 1'b0, rate_half = 1'b0, scramble = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       sym_out;

    int         n_cmp = 0;
    int         n_bad = 0;
    logic [6:0] m_sr  = '0;
    int         m_ph  = 0;
    logic       m_sym = 1'b0;
    logic [15:0] lf   = 16'hACE1;

    always #2 clk = ~clk;

    conv_symbol_encoder uut (
        .clk(clk), .rst_n(rst_n), .data_stb(data_stb), .data_in(data_in),
        .latch_stb(latch_stb), .auto_mode(auto_mode), .sel(sel),
        .rate_half(rate_half), .scramble(scramble), .sym_out(sym_out)
    );

    function automatic logic gsym(input int idx, input logic [6:0] st, input logic scr);
        logic [6:0] p;
        p = (idx == 0) ? 7'o171 : (idx == 1) ? 7'o133 : 7'o145;
        return (^(st & p)) ^ ((idx == 1) ? scr : 1'b0);
    endfunction

    task automatic chk(input string tag, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b (reg %b)", tag, got, exp, m_sr);
        end
    endtask

    function automatic logic next_bit();
        logic b;
        b  = lf[0];
        lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
        return b;
    endfunction

    task automatic step(input logic ds, input logic din, input logic ls, input logic am,
                        input logic [1:0] s, input logic rh, input logic scr, input string tag);
        @(negedge clk);
        data_stb = ds; data_in = din; latch_stb = ls; auto_mode = am;
        sel = s; rate_half = rh; scramble = scr;
        if (ls) begin
            if (am) begin
                m_sym = gsym(m_ph, m_sr, scr);
                m_ph  = (m_ph >= (rh ? 1 : 2)) ? 0 : m_ph + 1;
            end else if (s != 2'b11) begin
                m_sym = gsym((s == 2'b00) ? 0 : (s == 2'b10) ? 1 : 2, m_sr, scr);
            end
        end
        if (ds) begin
            m_sr = {m_sr[5:0], din};
            m_ph = 0;
        end
        @(posedge clk);
        #1;
        if (tag != "") chk(tag, sym_out, m_sym);
    endtask

    initial begin
        #800000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        chk("R1 output cleared during reset", sym_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: cleared register gives zero for every symbol
        step(0, 0, 1, 0, 2'b00, 0, 0, "R1 G1 of cleared register");
        step(0, 0, 1, 0, 2'b10, 0, 0, "R1 G2 of cleared register");
        step(0, 0, 1, 0, 2'b01, 0, 0, "R1 G3 of cleared register");

        // Exhaustive register contents in external mode
        for (int v = 0; v < 128; v++) begin
            for (int b = 6; b >= 0; b--) begin
                step(1, v[b], 0, 0, 2'b00, 0, 0, "");
            end
            step(0, 0, 0, 0, 2'(v), v[2], v[3], "R4 no change without output strobe");
            step(0, 0, 1, 0, 2'b00, v[1], 0, "R2 R3 R8 external G1");
            step(0, 0, 1, 0, 2'b10, v[1], v[0], "R3 R9 external G2 with scramble");
            step(0, 0, 1, 0, 2'b01, v[1], v[0], "R3 R8 R9 external G3 not scrambled");
            step(0, 0, 1, 0, 2'b11, v[4], v[5], "R5 hold code keeps output");
        end

        // Automatic rate 1/3
        for (int i = 0; i < 96; i++) begin
            step(1, next_bit(), 0, 1, 2'(i), 0, i[2], "");
            step(0, 0, 1, 1, 2'(i + 1), 0, i[2], "R6 rate third G1");
            step(0, 0, 1, 1, 2'(i + 2), 0, i[2], "R6 R9 rate third G2");
            step(0, 0, 1, 1, 2'(i + 3), 0, i[2], "R6 rate third G3");
            if (i % 4 == 0) step(0, 0, 1, 1, 2'(i), 0, i[2], "R6 rate third wraps to G1");
        end

        // Automatic rate 1/2
        for (int i = 0; i < 96; i++) begin
            step(1, next_bit(), 0, 1, 2'(i), 1, i[1], "");
            step(0, 0, 1, 1, 2'(i + 3), 1, i[1], "R7 rate half G1 sel ignored");
            step(0, 0, 1, 1, 2'(i + 1), 1, i[1], "R7 R9 rate half G2");
            if (i % 3 == 0) step(0, 0, 1, 1, 2'(i + 2), 1, i[1], "R7 rate half wraps to G1");
        end

        // Restart on data strobe mid-sequence
        for (int i = 0; i < 16; i++) begin
            step(1, next_bit(), 0, 1, 2'b00, 0, 0, "");
            step(0, 0, 1, 1, 2'b00, 0, 0, "R10 first G1");
            step(0, 0, 1, 1, 2'b00, 0, 0, "R10 then G2");
            step(1, next_bit(), 0, 1, 2'b00, 0, 0, "");
            step(0, 0, 1, 1, 2'b00, 0, 0, "R10 restart at G1");
        end

        // Simultaneous strobes
        for (int i = 0; i < 32; i++) begin
            step(1, next_bit(), 0, 1, 2'b00, i[0], i[1], "");
            step(0, 0, 1, 1, 2'b00, i[0], i[1], "R11 G1 before simultaneous");
            step(1, next_bit(), 1, 1, 2'b00, i[0], i[1], "R11 auto simultaneous uses old register");
            step(0, 0, 1, 1, 2'b00, i[0], i[1], "R11 G1 of shifted register");
            step(1, next_bit(), 1, 0, (i[2] ? 2'b10 : 2'b01), 0, i[1], "R11 external simultaneous");
            step(0, 0, 1, 0, 2'b00, 0, 0, "R11 external after shift");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule